// File: doc/BRIEF.md
# Bidirectional Energy Pulse Generator

This block turns a stream of signed per-sample power values into energy pulses. Two independent channels each keep a 48-bit signed energy accumulator, held as a high and a low 24-bit half. One channel is fed with active power and the other with reactive power. On every sample strobe, each channel adds its power value into its accumulator. It then compares the new total against a programmable energy quantum. When the quantum is crossed in the forward direction, the channel emits a one-clock pulse on its forward output and removes one quantum from the accumulator. When it is crossed in the reverse direction, the channel pulses its reverse output and gives one quantum back.

The active channel drives a consumed-energy output and a generated-energy output. The reactive channel drives an inductive (lagging) output and a capacitive (leading) output. A positive reactive value counts as inductive. The quantum is a single shared register that can be written at any time. Its reset value is a parameter chosen to equal one watt-hour, or one var-hour for the reactive channel, at the system's power scaling. Samples normally arrive thousands of clock cycles apart, so each channel processes one sample in a short three-state sequence.

Each channel is controlled by a small state machine with these states:
- `CH_IDLE` waits for a strobe. On a strobe it captures the power value and the current quantum and moves to `CH_ADD`.
- `CH_ADD` updates the accumulator and always moves to `CH_TEST`.
- `CH_TEST` decides whether to pulse and correct the accumulator, then always returns to `CH_IDLE`.

Top module: `ep_energy_pulser`

## Requirements
- R1: After reset, both accumulators are zero, the quantum equals the parameter `THR_DEFAULT` (1,000,000 by default), and all four pulse outputs are low.
- R2: A strobe sampled at a rising edge while the channel is idle starts processing. If the captured power is greater than zero and accumulator plus power (signed, 48 bits) is strictly greater than the quantum, the forward output pulses (`act_fwd` for active, `rea_lag` for reactive). The quantum is then subtracted from the accumulator.
- R3: If the captured power is less than zero and accumulator plus power is strictly less than the negated quantum, the reverse output pulses (`act_rev` for active, `rea_lead` for reactive). The quantum is then added to the accumulator.
- R4: In every other case, including a power of exactly zero and a sum exactly equal to ±quantum, the accumulator keeps the plain sum and no pulse is produced. The forward and reverse outputs of a channel are never high together.
- R5: A pulse is high for exactly one clock cycle. It rises at the second rising edge after the edge that accepted the strobe.
- R6: The reactive channel applies the same rule with its own accumulator and the reactive power value, independently of the active channel.
- R7: When `thr_we` is high at a rising edge, the quantum becomes `thr_wdata`. A sample accepted at that same edge still uses the previous quantum, and every later sample uses the new one.
- R8: A strobe that arrives at either of the two rising edges following an accepted strobe is ignored. It neither changes an accumulator nor causes a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | Sample strobe, one cycle per sample |
| p_act | input | 24 | Signed active power for this sample |
| p_react | input | 24 | Signed reactive power for this sample (positive = inductive) |
| thr_we | input | 1 | Quantum write enable |
| thr_wdata | input | 24 | New quantum value (unsigned) |
| act_fwd | output | 1 | Consumed active energy pulse |
| act_rev | output | 1 | Generated active energy pulse |
| rea_lag | output | 1 | Inductive reactive energy pulse |
| rea_lead | output | 1 | Capacitive reactive energy pulse |

## Verification
The following are checked on every cycle:
- each pulse lasts one cycle;
- forward and reverse never coincide;
- every pulse is preceded, three edges earlier, by a strobe;
- the power value at that strobe had the sign that matches the pulse direction;
- the quantum register follows its writes.

Whether a pulse should have been issued at all depends on the accumulated history. That can only be shown by the bench, which keeps an independent model of both accumulators. Its scenarios cover:
- the default quantum;
- exact-boundary sums;
- zero power;
- sign reversal;
- quantum writes coinciding with a sample;
- strobes arriving while a channel is busy;
- long random sequences.

// File: rtl/ep_pkg.sv
package ep_pkg;

    // Per-channel sequencing states
    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_ADD  = 2'd1,
        CH_TEST = 2'd2
    } ch_state_t;

    // Channel indices
    localparam int CH_ACT = 0;
    localparam int CH_REA = 1;
    localparam int N_CH   = 2;

endpackage

// File: rtl/ep_thr_reg.sv
module ep_thr_reg #(
    parameter int          T_W         = 24,
    parameter logic [T_W-1:0] THR_DEFAULT = T_W'(1000000)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [T_W-1:0] wdata,
    output logic [T_W-1:0] thr
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr <= THR_DEFAULT;
        end else if (we) begin
            thr <= wdata;
        end
    end

endmodule

// File: rtl/ep_chan.sv
module ep_chan
    import ep_pkg::*;
#(
    parameter int P_W    = 24,
    parameter int T_W    = 24,
    parameter int HALF_W = 24
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           stb,
    input  logic [P_W-1:0] pwr,
    input  logic [T_W-1:0] thr,
    output logic           pulse_pos,
    output logic           pulse_neg
);

    localparam int ACC_W = 2 * HALF_W;

    ch_state_t state, state_nx;

    logic [HALF_W-1:0] acc_hi, acc_lo;
    logic [P_W-1:0]    pwr_q;
    logic [T_W-1:0]    thr_q;

    logic signed [ACC_W-1:0] acc_s;
    logic signed [ACC_W-1:0] pwr_ext;
    logic signed [ACC_W-1:0] thr_ext;
    logic signed [ACC_W-1:0] sum_add;
    logic signed [ACC_W-1:0] sum_dec;
    logic signed [ACC_W-1:0] sum_inc;
    logic                    pwr_gt0, pwr_lt0;
    logic                    cross_pos, cross_neg;

    // Datapath views of the split accumulator
    always_comb begin
        acc_s     = $signed({acc_hi, acc_lo});
        pwr_ext   = $signed({{(ACC_W-P_W){pwr_q[P_W-1]}}, pwr_q});
        thr_ext   = $signed({{(ACC_W-T_W){1'b0}}, thr_q});
        sum_add   = acc_s + pwr_ext;
        sum_dec   = acc_s - thr_ext;
        sum_inc   = acc_s + thr_ext;
        pwr_lt0   = pwr_q[P_W-1];
        pwr_gt0   = !pwr_q[P_W-1] && (pwr_q != '0);
        cross_pos = pwr_gt0 && (acc_s > thr_ext);
        cross_neg = pwr_lt0 && (acc_s < -thr_ext);
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            CH_IDLE: if (stb) state_nx = CH_ADD;
            CH_ADD:  state_nx = CH_TEST;
            CH_TEST: state_nx = CH_IDLE;
            default: state_nx = CH_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CH_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Outputs and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_hi    <= '0;
            acc_lo    <= '0;
            pwr_q     <= '0;
            thr_q     <= '0;
            pulse_pos <= 1'b0;
            pulse_neg <= 1'b0;
        end else begin
            pulse_pos <= 1'b0;
            pulse_neg <= 1'b0;
            unique case (state)
                CH_IDLE: begin
                    if (stb) begin
                        pwr_q <= pwr;
                        thr_q <= thr;
                    end
                end
                CH_ADD: begin
                    {acc_hi, acc_lo} <= sum_add;
                end
                CH_TEST: begin
                    if (cross_pos) begin
                        {acc_hi, acc_lo} <= sum_dec;
                        pulse_pos        <= 1'b1;
                    end else if (cross_neg) begin
                        {acc_hi, acc_lo} <= sum_inc;
                        pulse_neg        <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ep_energy_pulser.sv
module ep_energy_pulser
    import ep_pkg::*;
#(
    parameter int             P_W         = 24,
    parameter int             T_W         = 24,
    parameter int             HALF_W      = 24,
    parameter logic [T_W-1:0] THR_DEFAULT = T_W'(1000000)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           smp_stb,
    input  logic [P_W-1:0] p_act,
    input  logic [P_W-1:0] p_react,
    input  logic           thr_we,
    input  logic [T_W-1:0] thr_wdata,
    output logic           act_fwd,
    output logic           act_rev,
    output logic           rea_lag,
    output logic           rea_lead
);

    logic [T_W-1:0] thr_q;
    logic [P_W-1:0] pwr_in [N_CH];
    logic [N_CH-1:0] pos_o, neg_o;

    assign pwr_in[CH_ACT] = p_act;
    assign pwr_in[CH_REA] = p_react;

    ep_thr_reg #(
        .T_W        (T_W),
        .THR_DEFAULT(THR_DEFAULT)
    ) u_thr (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (thr_we),
        .wdata(thr_wdata),
        .thr  (thr_q)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        ep_chan #(
            .P_W   (P_W),
            .T_W   (T_W),
            .HALF_W(HALF_W)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .stb      (smp_stb),
            .pwr      (pwr_in[c]),
            .thr      (thr_q),
            .pulse_pos(pos_o[c]),
            .pulse_neg(neg_o[c])
        );
    end

    assign act_fwd  = pos_o[CH_ACT];
    assign act_rev  = neg_o[CH_ACT];
    assign rea_lag  = pos_o[CH_REA];
    assign rea_lead = neg_o[CH_REA];

endmodule

// File: rtl/ep_checker.sv
module ep_checker #(
    parameter int P_W = 24,
    parameter int T_W = 24
) (
    input logic           clk,
    input logic           rst_n,
    input logic           smp_stb,
    input logic [P_W-1:0] p_act,
    input logic [P_W-1:0] p_react,
    input logic           thr_we,
    input logic [T_W-1:0] thr_wdata,
    input logic [T_W-1:0] thr_q,
    input logic           act_fwd,
    input logic           act_rev,
    input logic           rea_lag,
    input logic           rea_lead
);

    // R4: never both directions at once
    a_r4_act_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(act_fwd && act_rev));
    a_r4_rea_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rea_lag && rea_lead));

    // R5: single-cycle pulses
    a_r5_fwd_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        act_fwd |=> !act_fwd);
    a_r5_rev_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        act_rev |=> !act_rev);
    a_r5_lag_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rea_lag |=> !rea_lag);
    a_r5_lead_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rea_lead |=> !rea_lead);

    // R5: every pulse traces back to a strobe three edges earlier
    a_r5_pulse_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (act_fwd || act_rev || rea_lag || rea_lead) |-> $past(smp_stb, 3));

    // R2/R3: pulse direction matches the sign of the sampled power
    a_r2_fwd_sign: assert property (@(posedge clk) disable iff (!rst_n)
        act_fwd |-> ($signed($past(p_act, 3)) > 0));
    a_r3_rev_sign: assert property (@(posedge clk) disable iff (!rst_n)
        act_rev |-> ($signed($past(p_act, 3)) < 0));
    a_r6_lag_sign: assert property (@(posedge clk) disable iff (!rst_n)
        rea_lag |-> ($signed($past(p_react, 3)) > 0));
    a_r6_lead_sign: assert property (@(posedge clk) disable iff (!rst_n)
        rea_lead |-> ($signed($past(p_react, 3)) < 0));

    // R7: quantum follows writes
    a_r7_thr_write: assert property (@(posedge clk) disable iff (!rst_n)
        thr_we |=> (thr_q == $past(thr_wdata)));
    a_r7_thr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !thr_we |=> $stable(thr_q));

endmodule

bind ep_energy_pulser ep_checker #(
    .P_W(P_W),
    .T_W(T_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_stb  (smp_stb),
    .p_act    (p_act),
    .p_react  (p_react),
    .thr_we   (thr_we),
    .thr_wdata(thr_wdata),
    .thr_q    (thr_q),
    .act_fwd  (act_fwd),
    .act_rev  (act_rev),
    .rea_lag  (rea_lag),
    .rea_lead (rea_lead)
);

// File: tb/sim_ep_energy_pulser.sv
`timescale 1ns/1ps
module sim_ep_energy_pulser;

    localparam int THR_DEF = 1000000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        smp_stb;
    logic [23:0] p_act, p_react;
    logic        thr_we;
    logic [23:0] thr_wdata;
    logic        act_fwd, act_rev, rea_lag, rea_lead;

    int     n_chk = 0;
    int     n_bad = 0;
    longint acc_a = 0;
    longint acc_r = 0;
    longint thr_m = THR_DEF;
    bit     done  = 1'b0;

    always #10 clk = ~clk;

    ep_energy_pulser u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_stb  (smp_stb),
        .p_act    (p_act),
        .p_react  (p_react),
        .thr_we   (thr_we),
        .thr_wdata(thr_wdata),
        .act_fwd  (act_fwd),
        .act_rev  (act_rev),
        .rea_lag  (rea_lag),
        .rea_lead (rea_lead)
    );

    // Model of one channel step: returns {rev, fwd}
    function automatic logic [1:0] step(input longint p, inout longint acc, input longint t);
        acc = acc + p;
        if (p > 0 && acc > t) begin
            acc = acc - t;
            return 2'b01;
        end else if (p < 0 && acc < -t) begin
            acc = acc + t;
            return 2'b10;
        end
        return 2'b00;
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: outputs {lead,lag,rev,fwd} actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic thr_write(input int v);
        thr_we    = 1'b1;
        thr_wdata = v[23:0];
        @(negedge clk);
        thr_we    = 1'b0;
        thr_m     = v;
    endtask

    // One sample: optional same-edge quantum write, optional busy-time strobe
    task automatic do_sample(input int pa, input int pq, input bit wr, input int wv,
                             input bit poke, input string req);
        logic [1:0] ea, er;
        smp_stb   = 1'b1;
        p_act     = pa[23:0];
        p_react   = pq[23:0];
        thr_we    = wr;
        thr_wdata = wv[23:0];
        @(negedge clk);
        ea = step(pa, acc_a, thr_m);
        er = step(pq, acc_r, thr_m);
        if (wr) thr_m = wv;
        thr_we  = 1'b0;
        smp_stb = poke;
        if (poke) begin
            p_act   = 24'h7FFFFF;
            p_react = 24'h800001;
        end
        @(negedge clk);
        smp_stb = 1'b0;
        @(negedge clk);
        check(req, {rea_lead, rea_lag, act_rev, act_fwd}, {er, ea});
        @(negedge clk);
        check({req, " R5 width"}, {rea_lead, rea_lag, act_rev, act_fwd}, 4'b0000);
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240));
        rst_n = 1'b0; smp_stb = 1'b0; p_act = '0; p_react = '0;
        thr_we = 1'b0; thr_wdata = '0;
        repeat (4) @(negedge clk);
        check("R1 reset pulses", {rea_lead, rea_lag, act_rev, act_fwd}, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 default quantum: exact boundary then one more
        do_sample(THR_DEF, -THR_DEF, 0, 0, 0, "R1 default boundary R4");
        do_sample(1, -1, 0, 0, 0, "R1 default cross R2 R3");

        // R7 small quantum, written at the same edge as a sample
        do_sample(50, -50, 1, 100, 0, "R7 old quantum used");
        do_sample(60, -60, 0, 0, 0, "R7 new quantum R2 R3");
        // R4 zero power never pulses
        do_sample(0, 0, 0, 0, 0, "R4 zero power");
        // R4 sign mismatch: negative power on positive acc
        do_sample(100, 0, 0, 0, 0, "R4 setup");
        do_sample(-10, 10, 0, 0, 0, "R4 sign mismatch");
        // R6 independence: drive channels opposite
        do_sample(-300, 300, 0, 0, 0, "R6 opposite channels");
        do_sample(-300, 300, 0, 0, 0, "R6 opposite channels again");
        // R8 strobe while busy ignored
        do_sample(20, -20, 0, 0, 1, "R8 busy strobe");
        do_sample(20, -20, 0, 0, 0, "R8 after busy strobe");
        // Quantum zero edge
        thr_write(0);
        do_sample(1, -1, 0, 0, 0, "R2 R3 zero quantum");

        // Random phase
        for (int blk = 0; blk < 6; blk++) begin
            thr_write(int'($urandom_range(2000, 200)));
            for (int i = 0; i < 60; i++) begin
                int pa, pq;
                pa = int'($urandom_range(3000, 0)) - 1500;
                pq = int'($urandom_range(3000, 0)) - 1500;
                do_sample(pa, pq, ($urandom_range(15, 0) == 0), int'($urandom_range(2000, 200)),
                          ($urandom_range(7, 0) == 0), "R2 R3 R6 R8 random");
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule